// File: doc/BRIEF.md
# Row Dot-Product Sequencer

This block produces one element of a sparse matrix-vector product for each matrix row. The matrix is supplied in compressed-row form through three sources. A count FIFO gives the number of non-zero entries in each row. A column FIFO gives the column index of each of those entries. An external value memory holds the non-zero values in row order and is read at consecutive addresses. The dense vector is held in a small internal vector memory. Software or a loader writes it through a dedicated write port.

When a count is waiting and the block is idle, the block pops the count. It then pops that many column indices. Each index addresses the vector memory, and the value memory is read at the next sequential address. Each value/vector pair is multiplied in an 8-stage pipeline. The products go to an 8-stage adder loop that keeps 8 interleaved partial sums. Once the last product has landed, the partial sums are folded into one result. The result leaves with a one-cycle done pulse and the row's sequence number, which serves as the result-memory write address. Arithmetic is wrapping unsigned integer arithmetic at the data width.

Top module: `row_dot_seq`

## Requirements
- R1: A row count is popped (`cnt_pop`=1) only while the block is idle and `cnt_empty`=0. Exactly one count is popped per row.
- R2: For each row, `col_pop` is asserted exactly as many cycles as the popped count, and never while `col_empty`=1.
- R3: `val_addr` is 0 after reset. It advances by one for each column index popped, wraps modulo VAL_DEPTH (a power of two), and holds in every other cycle.
- R4: `res_data` equals the sum over the row of value[val_addr] × vector[column], computed modulo 2^DATA_W. No product is dropped or counted twice by the interleaved partial sums.
- R5: The vector memory is write-first. A write on the same clock edge as a read of the same address delivers the newly written word to the multiplier.
- R6: A row count of 0 produces one done pulse with `res_data`=0 and pops no column index.
- R7: A row count of 1 produces a result equal to that single product.
- R8: `res_done` is high for exactly one cycle per row. `res_row` carries the row sequence number, which is 0 for the first row after reset, rises by one per row, and wraps modulo 2^ROW_W.
- R9: No further count is popped between a row's count pop and its done pulse. Results therefore leave in the order the counts were queued.
- R10: While `col_empty`=1 during a row, the block stalls: `col_pop` stays 0, `val_addr` holds, and the row result is unaffected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_empty | input | 1 | Row-count FIFO is empty |
| cnt_data | input | CNT_W | Row count at the head of the count FIFO (show-ahead) |
| cnt_pop | output | 1 | Consume the head of the count FIFO |
| col_empty | input | 1 | Column FIFO is empty |
| col_data | input | log2(VEC_DEPTH) | Column index at the head of the column FIFO (show-ahead) |
| col_pop | output | 1 | Consume the head of the column FIFO |
| val_addr | output | log2(VAL_DEPTH) | Read address of the value memory |
| val_data | input | DATA_W | Value memory read data, one cycle after `val_addr` |
| vec_we | input | 1 | Vector memory write enable |
| vec_waddr | input | log2(VEC_DEPTH) | Vector memory write address |
| vec_wdata | input | DATA_W | Vector memory write data |
| res_done | output | 1 | One-cycle pulse: row result valid |
| res_row | output | ROW_W | Row sequence number, used as the result-memory address |
| res_data | output | DATA_W | Row dot product |

## Verification
The most likely internal faults show up on `res_data` when the matching done pulse arrives. Examples are a partial-sum slot reused before its previous sum has come back, a slot left uncleared between rows, or a reduction that skips a slot. Rows with lengths from 0 to 64 place the last product in every slot position, so a slot fault is visible on the next row of the right length. A miscounted issue loop shows up at the FIFO ports as a column-pop count that differs from the row count, and this is checked at each done. A wrong value pointer shows up both in the result and in `val_addr` once a batch has drained.

// File: rtl/row_dot_pkg.sv
package row_dot_pkg;

  // Sequencer phases of one row
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ISSUE  = 2'd1,
    ST_DRAIN  = 2'd2,
    ST_REDUCE = 2'd3
  } rd_state_e;

endpackage

// File: rtl/row_dot_vram.sv
module row_dot_vram #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 64,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  // Simple dual-port storage; a colliding read returns the word being written.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (we && (waddr == raddr)) rdata <= wdata;
    else                        rdata <= mem[raddr];
  end

endmodule

// File: rtl/row_dot_mulpipe.sv
module row_dot_mulpipe #(
  parameter int DATA_W = 32,
  parameter int LAT    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_v,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  output logic              out_v,
  output logic [DATA_W-1:0] out_p
);

  function automatic logic [DATA_W-1:0] f_mul(input logic [DATA_W-1:0] a,
                                              input logic [DATA_W-1:0] b);
    logic [DATA_W-1:0] r;
    r = a * b;
    return r;
  endfunction

  logic              stg_v [LAT];
  logic [DATA_W-1:0] stg_p [LAT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LAT; i++) stg_v[i] <= 1'b0;
    end else begin
      stg_v[0] <= in_v;
      for (int i = 1; i < LAT; i++) stg_v[i] <= stg_v[i-1];
    end
    stg_p[0] <= f_mul(in_a, in_b);
    for (int i = 1; i < LAT; i++) stg_p[i] <= stg_p[i-1];
  end

  assign out_v = stg_v[LAT-1];
  assign out_p = stg_p[LAT-1];

endmodule

// File: rtl/row_dot_accum.sv
module row_dot_accum #(
  parameter int DATA_W = 32,
  parameter int LAT    = 8,
  localparam int SW    = $clog2(LAT),
  localparam int NS    = LAT - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              in_v,
  input  logic [DATA_W-1:0] in_d,
  input  logic [SW-1:0]     rd_sel,
  output logic [DATA_W-1:0] rd_sum,
  output logic              wr_ev
);

  function automatic logic [DATA_W-1:0] f_add(input logic [DATA_W-1:0] a,
                                              input logic [DATA_W-1:0] b);
    logic [DATA_W-1:0] r;
    r = a + b;
    return r;
  endfunction

  logic [DATA_W-1:0] psum  [LAT];
  logic              stg_v [NS];
  logic [DATA_W-1:0] stg_d [NS];
  logic [SW-1:0]     stg_s [NS];
  logic [SW-1:0]     slot;
  logic              slot_busy;
  logic              any_busy;

  // Round-robin slot: consecutive products go to consecutive partial sums.
  always_ff @(posedge clk) begin
    if (!rst_n || clr) slot <= '0;
    else if (in_v)     slot <= (slot == SW'(LAT-1)) ? '0 : slot + 1'b1;
  end

  // Adder pipeline; its last stage is the write into the partial sum.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NS; i++) stg_v[i] <= 1'b0;
    end else begin
      stg_v[0] <= in_v;
      for (int i = 1; i < NS; i++) stg_v[i] <= stg_v[i-1];
    end
    stg_d[0] <= f_add(in_d, psum[slot]);
    stg_s[0] <= slot;
    for (int i = 1; i < NS; i++) begin
      stg_d[i] <= stg_d[i-1];
      stg_s[i] <= stg_s[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      for (int i = 0; i < LAT; i++) psum[i] <= '0;
    end else if (stg_v[NS-1]) begin
      psum[stg_s[NS-1]] <= stg_d[NS-1];
    end
  end

  assign rd_sum = psum[rd_sel];
  assign wr_ev  = stg_v[NS-1];

  always_comb begin
    slot_busy = 1'b0;
    any_busy  = 1'b0;
    for (int i = 0; i < NS; i++) begin
      if (stg_v[i] && (stg_s[i] == slot)) slot_busy = 1'b1;
      if (stg_v[i]) any_busy = 1'b1;
    end
  end

  // R4
  slot_hazard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_v |-> !slot_busy);

  // R9
  clear_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |-> (!any_busy && !in_v));

endmodule

// File: rtl/row_dot_seq.sv
module row_dot_seq
  import row_dot_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int VEC_DEPTH = 64,
  parameter int VAL_DEPTH = 1024,
  parameter int CNT_W     = 11,
  parameter int ROW_W     = 6,
  parameter int MUL_LAT   = 8,
  parameter int ADD_LAT   = 8,
  localparam int VEC_AW   = $clog2(VEC_DEPTH),
  localparam int VAL_AW   = $clog2(VAL_DEPTH),
  localparam int SW       = $clog2(ADD_LAT),
  localparam int FLY_MAX  = 1 + MUL_LAT + ADD_LAT,
  localparam int FLY_W    = $clog2(FLY_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_empty,
  input  logic [CNT_W-1:0]  cnt_data,
  output logic              cnt_pop,
  input  logic              col_empty,
  input  logic [VEC_AW-1:0] col_data,
  output logic              col_pop,
  output logic [VAL_AW-1:0] val_addr,
  input  logic [DATA_W-1:0] val_data,
  input  logic              vec_we,
  input  logic [VEC_AW-1:0] vec_waddr,
  input  logic [DATA_W-1:0] vec_wdata,
  output logic              res_done,
  output logic [ROW_W-1:0]  res_row,
  output logic [DATA_W-1:0] res_data
);

  function automatic logic [DATA_W-1:0] f_add(input logic [DATA_W-1:0] a,
                                              input logic [DATA_W-1:0] b);
    logic [DATA_W-1:0] r;
    r = a + b;
    return r;
  endfunction

  rd_state_e         state;
  logic [CNT_W-1:0]  remain;
  logic [VAL_AW-1:0] val_ptr;
  logic              op_v;
  logic [FLY_W-1:0]  fly;
  logic [SW-1:0]     red_idx;
  logic [DATA_W-1:0] red_acc;
  logic [ROW_W-1:0]  row_seq;

  logic              issue;
  logic              row_start;
  logic [DATA_W-1:0] vec_rd;
  logic              prod_v;
  logic [DATA_W-1:0] prod_d;
  logic [DATA_W-1:0] part_sum;
  logic              acc_wr;
  logic              last_fold;

  // Named events for the checks below
  assign row_start = (state == ST_IDLE) && !cnt_empty;
  assign issue     = (state == ST_ISSUE) && (remain != '0) && !col_empty;
  assign last_fold = (state == ST_REDUCE) && (red_idx == SW'(ADD_LAT-1));

  assign cnt_pop  = row_start;
  assign col_pop  = issue;
  assign val_addr = val_ptr;

  row_dot_vram #(.DATA_W(DATA_W), .DEPTH(VEC_DEPTH)) u_vram (
    .clk   (clk),
    .we    (vec_we),
    .waddr (vec_waddr),
    .wdata (vec_wdata),
    .raddr (col_data),
    .rdata (vec_rd)
  );

  row_dot_mulpipe #(.DATA_W(DATA_W), .LAT(MUL_LAT)) u_mul (
    .clk   (clk),
    .rst_n (rst_n),
    .in_v  (op_v),
    .in_a  (val_data),
    .in_b  (vec_rd),
    .out_v (prod_v),
    .out_p (prod_d)
  );

  row_dot_accum #(.DATA_W(DATA_W), .LAT(ADD_LAT)) u_acc (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (row_start),
    .in_v   (prod_v),
    .in_d   (prod_d),
    .rd_sel (red_idx),
    .rd_sum (part_sum),
    .wr_ev  (acc_wr)
  );

  // Operands arrive one cycle after the pop (registered reads on both sides).
  always_ff @(posedge clk) begin
    if (!rst_n) op_v <= 1'b0;
    else        op_v <= issue;
  end

  // Products still travelling through read, multiply and add
  always_ff @(posedge clk) begin
    if (!rst_n) fly <= '0;
    else begin
      case ({issue, acc_wr})
        2'b10:   fly <= fly + 1'b1;
        2'b01:   fly <= fly - 1'b1;
        default: fly <= fly;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) val_ptr <= '0;
    else if (issue) val_ptr <= val_ptr + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      remain   <= '0;
      red_idx  <= '0;
      red_acc  <= '0;
      row_seq  <= '0;
      res_done <= 1'b0;
      res_row  <= '0;
      res_data <= '0;
    end else begin
      res_done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (row_start) begin
            remain <= cnt_data;
            state  <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (remain == '0)  state  <= ST_DRAIN;
          else if (issue)    remain <= remain - 1'b1;
        end
        ST_DRAIN: begin
          if (fly == '0) begin
            red_idx <= '0;
            red_acc <= '0;
            state   <= ST_REDUCE;
          end
        end
        ST_REDUCE: begin
          red_acc <= f_add(red_acc, part_sum);
          red_idx <= red_idx + 1'b1;
          if (last_fold) begin
            res_done <= 1'b1;
            res_data <= f_add(red_acc, part_sum);
            res_row  <= row_seq;
            row_seq  <= row_seq + 1'b1;
            state    <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Checker state: column pops seen in the current row against its count
  logic [CNT_W-1:0] chk_cnt;
  logic [CNT_W-1:0] chk_pops;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chk_cnt  <= '0;
      chk_pops <= '0;
    end else if (cnt_pop) begin
      chk_cnt  <= cnt_data;
      chk_pops <= '0;
    end else if (col_pop) begin
      chk_pops <= chk_pops + 1'b1;
    end
  end

  // R2
  pop_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_done |-> (chk_pops == chk_cnt));

  // R3
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !col_pop |=> $stable(val_addr));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_done |=> !res_done);

  // R4
  fly_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_wr |-> (fly != '0));

  // R9
  idle_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_pop |-> (fly == '0));

  // R4
  done_settled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_done |-> (fly == '0 && !prod_v));

endmodule

// File: tb/row_dot_seq_tb.sv
module row_dot_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W     = 32;
  localparam int CNT_W      = 11;
  localparam int ROW_W      = 6;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_empty, cnt_pop, col_empty, col_pop;
  logic [CNT_W-1:0] cnt_data;
  logic [5:0]  col_data;
  logic [9:0]  val_addr;
  logic [31:0] val_data;
  logic        vec_we = 1'b0;
  logic [5:0]  vec_waddr = '0;
  logic [31:0] vec_wdata = '0;
  logic        res_done;
  logic [ROW_W-1:0] res_row;
  logic [31:0] res_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  row_dot_seq u_dut (
    .clk(clk), .rst_n(rst_n),
    .cnt_empty(cnt_empty), .cnt_data(cnt_data), .cnt_pop(cnt_pop),
    .col_empty(col_empty), .col_data(col_data), .col_pop(col_pop),
    .val_addr(val_addr), .val_data(val_data),
    .vec_we(vec_we), .vec_waddr(vec_waddr), .vec_wdata(vec_wdata),
    .res_done(res_done), .res_row(res_row), .res_data(res_data)
  );

  int checks = 0;
  int errors = 0;

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Show-ahead FIFO and memory models
  logic [CNT_W-1:0] cnt_mem [256];
  logic [5:0]  col_mem [4096];
  logic [31:0] vmem [1024];
  logic [31:0] vref [64];
  int cnt_wp = 0, cnt_rp = 0, col_wp = 0, col_rp = 0;
  bit col_hold = 1'b0;

  assign cnt_empty = (cnt_wp == cnt_rp);
  assign cnt_data  = cnt_mem[cnt_rp % 256];
  assign col_empty = (col_wp == col_rp) || col_hold;
  assign col_data  = col_mem[col_rp % 4096];

  always @(posedge clk) begin
    if (cnt_pop) cnt_rp <= cnt_rp + 1;
    if (col_pop) col_rp <= col_rp + 1;
    val_data <= vmem[val_addr];
  end

  // Expected results, in row order
  logic [31:0] exp_val [512];
  int exp_n [512];
  int exp_row [512];
  int eh = 0, et = 0;
  int vptr = 0;
  int row_ctr = 0;

  task automatic push_row(input int n, input int vpat, input bit same_col,
                          input int fixed_col);
    logic [31:0] acc = '0;
    for (int k = 0; k < n; k++) begin
      int c;
      logic [31:0] v;
      c = same_col ? fixed_col : int'($urandom % 64);
      v = (vpat == 1) ? 32'hFFFF_FFFF : (vpat == 2) ? 32'(k + 1) : $urandom;
      vmem[vptr] = v;
      vptr = (vptr + 1) % 1024;
      col_mem[col_wp % 4096] = 6'(c);
      col_wp++;
      acc = acc + v * vref[c];
    end
    exp_val[et % 512] = acc;
    exp_n[et % 512]   = n;
    exp_row[et % 512] = row_ctr % 64;
    row_ctr++;
    et++;
    cnt_mem[cnt_wp % 256] = CNT_W'(n);
    cnt_wp++;
  endtask

  task automatic drain();
    while (eh != et) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic write_vec(input int a, input logic [31:0] d);
    vec_we = 1'b1; vec_waddr = 6'(a); vec_wdata = d;
    vref[a] = d;
    @(negedge clk);
    vec_we = 1'b0;
  endtask

  // Port monitor
  int cpops = 0, kpops = 0;
  bit prev_done = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (res_done) begin
        if (eh == et) begin
          check(1'b0, "R9 unexpected done", 32'(res_row), 32'hFFFF_FFFF);
        end else begin
          int i;
          string tag;
          i = eh % 512;
          tag = (exp_n[i] == 0) ? "R6 zero row" :
                (exp_n[i] == 1) ? "R7 single row" : "R4 row sum";
          check(res_data == exp_val[i], tag, res_data, exp_val[i]);
          check(32'(res_row) == 32'(exp_row[i]), "R8 row number",
                32'(res_row), 32'(exp_row[i]));
          check(kpops == exp_n[i], "R2 column pops", 32'(kpops), 32'(exp_n[i]));
          check(cpops == 1, "R9 R1 count pops per row", 32'(cpops), 32'd1);
          eh++;
        end
        cpops = 0;
        kpops = 0;
        check(!prev_done, "R8 pulse width", 32'(prev_done), 32'd0);
      end
      if (cnt_pop) begin
        cpops++;
        check(!cnt_empty, "R1 pop of empty count FIFO", 32'(cnt_empty), 32'd0);
      end
      if (col_pop) begin
        kpops++;
        check(!col_empty, "R2 R10 pop of empty column FIFO", 32'(col_empty), 32'd0);
      end
      prev_done = res_done;
    end
  end

  // Watchdog
  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=<%0d", cycles, WATCHDOG);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // Reset state
    check(res_done == 1'b0, "R8 reset done", 32'(res_done), 32'd0);
    check(val_addr == 10'd0, "R3 reset address", 32'(val_addr), 32'd0);
    check(cnt_pop == 1'b0, "R1 reset pop", 32'(cnt_pop), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(col_pop == 1'b0, "R2 idle column pop", 32'(col_pop), 32'd0);

    for (int a = 0; a < 64; a++) write_vec(a, (a % 5 == 0) ? 32'hFFFF_FFF0 + 32'(a) : $urandom);

    // R7: single product, then R6: empty row
    push_row(1, 0, 1'b0, 0);
    drain();
    push_row(0, 0, 1'b0, 0);
    drain();

    // Length sweep, queued four rows at a time to overlap counts (R9)
    for (int b = 0; b < 18; b++) begin
      for (int j = 0; j < 4; j++) begin
        int r;
        r = b * 4 + j;
        push_row((r * 7) % 29, r % 3, (b % 4) == 1, r % 64);
      end
      drain();
      check(32'(val_addr) == 32'(vptr), "R3 address after batch", 32'(val_addr), 32'(vptr));
    end

    // Long rows push the value pointer across its wrap
    for (int j = 0; j < 3; j++) push_row(64, j, 1'b0, 0);
    drain();
    check(32'(val_addr) == 32'(vptr), "R3 address after wrap", 32'(val_addr), 32'(vptr));

    // R10: column FIFO starved mid-row
    begin
      int hold_ptr;
      hold_ptr = vptr;
      col_hold = 1'b1;
      push_row(5, 0, 1'b0, 0);
      repeat (30) @(negedge clk);
      check(32'(val_addr) == 32'(hold_ptr), "R10 address held", 32'(val_addr), 32'(hold_ptr));
      check(eh != et, "R10 no result while starved", 32'(eh), 32'(et - 1));
      col_hold = 1'b0;
      drain();
    end

    // R5: overwrite the addressed vector word on the read edge
    begin
      logic [31:0] nw;
      nw = 32'h0001_2345;
      vref[9] = nw;
      push_row(1, 2, 1'b1, 9);
      do @(negedge clk); while (!col_pop);
      vec_we = 1'b1; vec_waddr = 6'd9; vec_wdata = nw;
      @(negedge clk);
      vec_we = 1'b0;
      drain();
    end

    check(eh == et, "R9 all rows returned", 32'(eh), 32'(et));
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule